// File: doc/BRIEF.md
# Event-Sequenced Timer

A single counter with a small table of programmable events around it. The counter can count up or down. Each event watches either one input pin or the counter value against one of several match registers. A mask tied to the current value of a state register decides whether the event may fire. When an event fires, it can move the state register to a new value, drive output pins high or low, and start, stop or reverse the counter. Several events can fire at the same clock edge, and all of their effects are applied together at that edge. With this, the block can sequence timed pin activity on its own, without software stepping it through each phase.

Software sets the block up through a write-only configuration port. The port holds an 8-bit address: the upper nibble picks a register group and the lower nibble picks the match or event index. After that, the block runs from its counter and its input pins. An output vector carries one flag per event, high for one cycle after that event fires.

Top module: `evt_tmr`

## Requirements
- R1: While reset is asserted and after it is released, the pins, the event flags, the state register and the counter are all zero, and the counter is stopped, counting up.
- R2: A write with cfg_we_i high is stored at the next clock edge, using this address map:
  - 0x00 control: bit 0 writes the run flag, bit 1 selects bounce mode.
  - 0x01 conflict codes: two bits per pin k at [2k+1:2k].
  - 0x10+m: match register m.
  - 0x20+e: trigger of event e. Bits [1:0] give the source (0 match, 1 rising edge, 2 falling edge, 3 high level) and bits [7:4] select the match register or input pin.
  - 0x30+e: state mask of event e.
  - 0x40+e: set mask of event e.
  - 0x50+e: clear mask of event e.
  - 0x60+e: action word of event e. Bit 0 loads the state, [7:4] is the new state, bit 8 starts, bit 9 stops, bit 10 reverses.
- R3: When the counter is running upward without bounce mode, it increments each cycle. On reaching the limit (match register 0) it returns to zero at the next edge.
- R4: In bounce mode, a counter running upward that reaches the limit moves to limit-1 and continues downward. In any mode, a counter running downward that reaches zero moves to 1 and continues upward.
- R5: A match-sourced event is true while the counter runs and equals the selected match register. Its flag on evt_o rises one cycle later.
- R6: An input-sourced event is true on a rising edge, a falling edge or a high level of the selected pin. Edges are found against the value the pin had in the previous cycle.
- R7: An event fires only when bit s of its state mask is set, where s is the current state. A reset mask disables the event.
- R8: A firing event with the load bit set writes its new-state field into the state register. When several such events fire together, the lowest index wins. Without a firing event the state is unchanged.
- R9: A pin that is only set goes high, and a pin that is only cleared goes low. A pin that is both set and cleared follows its conflict code: 0 keep, 1 high, 2 low, 3 toggle. Without a firing event the pins are unchanged.
- R10: A start action sets the run flag and a stop action clears it, with stop taking priority. Both take priority over a control write. A stopped counter holds its value. A reverse action inverts the direction that the counter would otherwise take at that edge, including a turn made at the limit in the same cycle.
- R11: All events that fire together apply their actions at the same edge, and each of them shows its own bit on evt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration address: group in [7:4], index in [3:0] |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| pin_i | input | N_IN | Input pins that events watch |
| pin_o | output | N_OUT | Output pins driven by event actions |
| evt_o | output | N_EVT | One-cycle flag per event that fired |

## Verification
The tightest coincidence in this block is a reverse action landing on the same edge as the bounce turn at the limit. The bench provokes it by placing a reverse event on the limit match in bounce mode. If the two effects combine correctly, the counter oscillates between limit and limit-1, and the reverse event's flag recurs every second cycle. Any other result makes the counter descend to a lower match value, which raises a second event's flag that the scoreboard does not expect. A second coincidence is two input-sourced events firing on the same rising edge, one setting and one clearing the same pins. The bench judges this from the pins that result under two different conflict codes, together with the combined flags on evt_o.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int SEL_W    = 4;
  localparam int MAX_ST_W = 4;

  localparam logic [3:0] PG_CTRL  = 4'h0;
  localparam logic [3:0] PG_MATCH = 4'h1;
  localparam logic [3:0] PG_TRIG  = 4'h2;
  localparam logic [3:0] PG_SMASK = 4'h3;
  localparam logic [3:0] PG_SETM  = 4'h4;
  localparam logic [3:0] PG_CLRM  = 4'h5;
  localparam logic [3:0] PG_ACT   = 4'h6;

  typedef enum logic [1:0] {
    SRC_MATCH = 2'd0,
    SRC_RISE  = 2'd1,
    SRC_FALL  = 2'd2,
    SRC_HIGH  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    RES_KEEP = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2,
    RES_TGL  = 2'd3
  } res_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    src_e             src;
  } trig_t;

  typedef struct packed {
    logic                rev;
    logic                stop;
    logic                start;
    logic [MAX_ST_W-1:0] nxt;
    logic                ld;
  } act_t;
endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int N_EVT   = 8,
  parameter int N_MATCH = 4,
  parameter int N_STATE = 8,
  parameter int N_OUT   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [7:0]                        addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic                              ctrl_we_o,
  output logic                              ctrl_run_o,
  output logic                              bidir_o,
  output logic [N_OUT-1:0][1:0]             res_o,
  output logic [N_MATCH-1:0][CNT_W-1:0]     match_o,
  output trig_t [N_EVT-1:0]                 trig_o,
  output logic [N_EVT-1:0][N_STATE-1:0]     smask_o,
  output logic [N_EVT-1:0][N_OUT-1:0]       setm_o,
  output logic [N_EVT-1:0][N_OUT-1:0]       clrm_o,
  output act_t [N_EVT-1:0]                  act_o
);
  logic [3:0] page, idx;
  assign page = addr_i[7:4];
  assign idx  = addr_i[3:0];

  assign ctrl_we_o  = we_i && (page == PG_CTRL) && (idx == 4'd0);
  assign ctrl_run_o = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bidir_o <= 1'b0;
      res_o   <= '0;
      match_o <= '0;
      trig_o  <= '0;
      smask_o <= '0;
      setm_o  <= '0;
      clrm_o  <= '0;
      act_o   <= '0;
    end else if (we_i) begin
      case (page)
        PG_CTRL: begin
          if (idx == 4'd0) bidir_o <= wdata_i[1];
          if (idx == 4'd1) res_o   <= wdata_i[2*N_OUT-1:0];
        end
        PG_MATCH:
          for (int m = 0; m < N_MATCH; m++)
            if (int'(idx) == m) match_o[m] <= wdata_i[CNT_W-1:0];
        default:
          for (int e = 0; e < N_EVT; e++) begin
            if (int'(idx) == e) begin
              case (page)
                PG_TRIG:  trig_o[e]  <= '{sel: wdata_i[7:4], src: src_e'(wdata_i[1:0])};
                PG_SMASK: smask_o[e] <= wdata_i[N_STATE-1:0];
                PG_SETM:  setm_o[e]  <= wdata_i[N_OUT-1:0];
                PG_CLRM:  clrm_o[e]  <= wdata_i[N_OUT-1:0];
                PG_ACT:   act_o[e]   <= '{rev: wdata_i[10], stop: wdata_i[9],
                                          start: wdata_i[8], nxt: wdata_i[7:4],
                                          ld: wdata_i[0]};
                default: ;
              endcase
            end
          end
      endcase
    end
  end
endmodule

// File: rtl/evt_tmr_cnt.sv
module evt_tmr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             bidir_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_run_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             dn_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             dn_auto, dn_nxt, run_nxt;

  always_comb begin
    cnt_nxt = cnt_o;
    dn_auto = dn_o;
    if (!dn_o) begin
      if (cnt_o >= limit_i) begin
        if (bidir_i && cnt_o != '0) begin
          cnt_nxt = cnt_o - 1'b1;
          dn_auto = 1'b1;
        end else begin
          cnt_nxt = '0;
        end
      end else begin
        cnt_nxt = cnt_o + 1'b1;
      end
    end else if (cnt_o == '0) begin
      cnt_nxt = CNT_W'(1);
      dn_auto = 1'b0;
    end else begin
      cnt_nxt = cnt_o - 1'b1;
    end
  end

  // reverse flips whatever direction this edge would otherwise leave
  assign dn_nxt = (run_o ? dn_auto : dn_o) ^ rev_i;

  always_comb begin
    run_nxt = run_o;
    if (ctrl_we_i) run_nxt = ctrl_run_i;
    if (start_i)   run_nxt = 1'b1;
    if (stop_i)    run_nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      run_o <= 1'b0;
      dn_o  <= 1'b0;
    end else begin
      if (run_o) cnt_o <= cnt_nxt;
      run_o <= run_nxt;
      dn_o  <= dn_nxt;
    end
  end
endmodule

// File: rtl/evt_tmr_trig.sv
module evt_tmr_trig
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 4,
  parameter int N_STATE = 8,
  parameter int N_IN    = 4,
  localparam int ST_W   = (N_STATE > 1) ? $clog2(N_STATE) : 1
) (
  input  trig_t                          trig_i,
  input  logic [N_STATE-1:0]             smask_i,
  input  logic [ST_W-1:0]                state_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic                           run_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0]  match_i,
  input  logic [N_IN-1:0]                pin_i,
  input  logic [N_IN-1:0]                pin_q_i,
  output logic                           fire_o
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    case (trig_i.src)
      SRC_MATCH:
        for (int m = 0; m < N_MATCH; m++)
          if (int'(trig_i.sel) == m) hit = run_i && (cnt_i == match_i[m]);
      SRC_RISE:
        for (int k = 0; k < N_IN; k++)
          if (int'(trig_i.sel) == k) hit = pin_i[k] && !pin_q_i[k];
      SRC_FALL:
        for (int k = 0; k < N_IN; k++)
          if (int'(trig_i.sel) == k) hit = !pin_i[k] && pin_q_i[k];
      SRC_HIGH:
        for (int k = 0; k < N_IN; k++)
          if (int'(trig_i.sel) == k) hit = pin_i[k];
      default: hit = 1'b0;
    endcase
  end

  assign fire_o = hit && smask_i[state_i];
endmodule

// File: rtl/evt_tmr_act.sv
module evt_tmr_act
  import evt_tmr_pkg::*;
#(
  parameter int N_EVT   = 8,
  parameter int N_STATE = 8,
  parameter int N_OUT   = 4,
  localparam int ST_W   = (N_STATE > 1) ? $clog2(N_STATE) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_EVT-1:0]            fire_i,
  input  logic [N_EVT-1:0][N_OUT-1:0] setm_i,
  input  logic [N_EVT-1:0][N_OUT-1:0] clrm_i,
  input  act_t [N_EVT-1:0]            act_i,
  input  logic [N_OUT-1:0][1:0]       res_i,
  output logic [N_OUT-1:0]            pin_o,
  output logic [N_EVT-1:0]            evt_o,
  output logic [ST_W-1:0]             state_o,
  output logic                        start_o,
  output logic                        stop_o,
  output logic                        rev_o
);
  logic [N_OUT-1:0] set_any, clr_any, pin_nxt;
  logic [ST_W-1:0]  st_nxt;

  always_comb begin
    set_any = '0;
    clr_any = '0;
    start_o = 1'b0;
    stop_o  = 1'b0;
    rev_o   = 1'b0;
    st_nxt  = state_o;
    // descending scan: lowest index loading the state wins
    for (int e = N_EVT - 1; e >= 0; e--) begin
      if (fire_i[e]) begin
        set_any = set_any | setm_i[e];
        clr_any = clr_any | clrm_i[e];
        start_o = start_o | act_i[e].start;
        stop_o  = stop_o  | act_i[e].stop;
        rev_o   = rev_o   | act_i[e].rev;
        if (act_i[e].ld) st_nxt = act_i[e].nxt[ST_W-1:0];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      case ({set_any[k], clr_any[k]})
        2'b10:   pin_nxt[k] = 1'b1;
        2'b01:   pin_nxt[k] = 1'b0;
        2'b11: begin
          case (res_e'(res_i[k]))
            RES_SET: pin_nxt[k] = 1'b1;
            RES_CLR: pin_nxt[k] = 1'b0;
            RES_TGL: pin_nxt[k] = !pin_o[k];
            default: pin_nxt[k] = pin_o[k];
          endcase
        end
        default: pin_nxt[k] = pin_o[k];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o   <= '0;
      evt_o   <= '0;
      state_o <= '0;
    end else begin
      pin_o   <= pin_nxt;
      evt_o   <= fire_i;
      state_o <= st_nxt;
    end
  end
endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 16,
  parameter int N_EVT   = 8,
  parameter int N_MATCH = 4,
  parameter int N_STATE = 8,
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [N_IN-1:0]   pin_i,
  output logic [N_OUT-1:0]  pin_o,
  output logic [N_EVT-1:0]  evt_o
);
  localparam int ST_W = (N_STATE > 1) ? $clog2(N_STATE) : 1;

  logic                          ctrl_we, ctrl_run, bidir_q;
  logic [N_OUT-1:0][1:0]         res_q;
  logic [N_MATCH-1:0][CNT_W-1:0] match_q;
  trig_t [N_EVT-1:0]             trig_q;
  logic [N_EVT-1:0][N_STATE-1:0] smask_q;
  logic [N_EVT-1:0][N_OUT-1:0]   setm_q, clrm_q;
  act_t [N_EVT-1:0]              act_q;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, dn_q;
  logic [ST_W-1:0]  state_q;
  logic [N_IN-1:0]  pin_q;
  logic [N_EVT-1:0] fire;
  logic             start_any, stop_any, rev_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  evt_tmr_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .N_EVT(N_EVT),
    .N_MATCH(N_MATCH), .N_STATE(N_STATE), .N_OUT(N_OUT)
  ) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .ctrl_we_o  (ctrl_we),
    .ctrl_run_o (ctrl_run),
    .bidir_o    (bidir_q),
    .res_o      (res_q),
    .match_o    (match_q),
    .trig_o     (trig_q),
    .smask_o    (smask_q),
    .setm_o     (setm_q),
    .clrm_o     (clrm_q),
    .act_o      (act_q)
  );

  evt_tmr_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .limit_i    (match_q[0]),
    .bidir_i    (bidir_q),
    .ctrl_we_i  (ctrl_we),
    .ctrl_run_i (ctrl_run),
    .start_i    (start_any),
    .stop_i     (stop_any),
    .rev_i      (rev_any),
    .cnt_o      (cnt_q),
    .run_o      (run_q),
    .dn_o       (dn_q)
  );

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    evt_tmr_trig #(
      .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_STATE(N_STATE), .N_IN(N_IN)
    ) trig_i (
      .trig_i  (trig_q[e]),
      .smask_i (smask_q[e]),
      .state_i (state_q),
      .cnt_i   (cnt_q),
      .run_i   (run_q),
      .match_i (match_q),
      .pin_i   (pin_i),
      .pin_q_i (pin_q),
      .fire_o  (fire[e])
    );
  end

  evt_tmr_act #(.N_EVT(N_EVT), .N_STATE(N_STATE), .N_OUT(N_OUT)) act_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .setm_i  (setm_q),
    .clrm_i  (clrm_q),
    .act_i   (act_q),
    .res_i   (res_q),
    .pin_o   (pin_o),
    .evt_o   (evt_o),
    .state_o (state_q),
    .start_o (start_any),
    .stop_o  (stop_any),
    .rev_o   (rev_any)
  );
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
  parameter int CNT_W = 16,
  parameter int ST_W  = 3,
  parameter int N_OUT = 4,
  parameter int N_EVT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             run_i,
  input logic             dn_i,
  input logic             bidir_i,
  input logic [CNT_W-1:0] lim_i,
  input logic [ST_W-1:0]  state_i,
  input logic [N_OUT-1:0] pins_i,
  input logic [N_EVT-1:0] evt_i
);
  assert_count_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !dn_i && cnt_i < lim_i |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !dn_i && !bidir_i && cnt_i >= lim_i |=> cnt_i == '0);

  assert_turn_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !dn_i && bidir_i && cnt_i >= lim_i && cnt_i != '0
    |=> cnt_i == $past(cnt_i) - 1'b1);

  assert_turn_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && dn_i && cnt_i == '0 |=> cnt_i == CNT_W'(1));

  assert_hold_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  assert_pins_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i == '0 |-> $stable(pins_i));

  assert_state_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i == '0 |-> $stable(state_i));
endmodule

bind evt_tmr evt_tmr_chk #(
  .CNT_W(CNT_W), .ST_W(ST_W), .N_OUT(N_OUT), .N_EVT(N_EVT)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_q),
  .run_i   (run_q),
  .dn_i    (dn_q),
  .bidir_i (bidir_q),
  .lim_i   (match_q[0]),
  .state_i (state_q),
  .pins_i  (pin_o),
  .evt_i   (evt_o)
);

// File: tb/evt_tmr_tb_top.sv
module evt_tmr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [3:0]  pin_in;
  logic [3:0]  pin_out;
  logic [7:0]  evt;

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] evt;
    logic [3:0] pins;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t cur;
  int   n_cmp = 0;
  int   n_bad = 0;

  // scenario traces, one entry per cycle after the start stimulus
  localparam logic [7:0] S1_EV [12] = '{0,0,0,1,0,2,0,0,0,1,0,2};
  localparam logic [3:0] S1_PN [12] = '{0,0,0,1,1,0,0,0,0,1,1,0};
  localparam logic [7:0] S2_EV [12] = '{0,0,0,0,1,0,2,0,4,0,0,0};
  localparam logic [3:0] S2_PN [12] = '{0,0,0,0,2,2,6,6,14,14,14,14};
  localparam logic [7:0] S3_EV [15] = '{0,3,0,0,8,0,4,0,0,0,8,0,0,0,8};
  localparam logic [3:0] S3_PN [15] = '{0,2,2,2,6,6,6,6,6,6,6,6,6,6,6};
  localparam logic [7:0] S4_EV [12] = '{0,0,2,0,1,0,1,0,1,0,1,0};
  localparam logic [3:0] S4_PN [12] = '{0,0,1,1,1,1,1,1,1,1,1,1};

  evt_tmr dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .pin_i       (pin_in),
    .pin_o       (pin_out),
    .evt_o       (evt)
  );

  // monitor: pops one expected item per cycle while the queue is filled
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_cmp++;
      if (evt !== cur.evt || pin_out !== cur.pins) begin
        n_bad++;
        $display("FAIL %s: evt=%h pins=%h expected evt=%h pins=%h",
                 cur.tag, evt, pin_out, cur.evt, cur.pins);
      end
    end
  end

  task automatic push(input logic [7:0] e, input logic [3:0] p, input string tag);
    exp_t x;
    x.evt = e; x.pins = p; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic do_reset();
    #1;
    rst_n  = 1'b0;
    pin_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (pin_out !== 4'h0 || evt !== 8'h00) begin
      n_bad++;
      $display("FAIL R1: pins=%h evt=%h expected pins=0 evt=00", pin_out, evt);
    end
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    do_reset();

    // S1: R2 R3 R5 wrap count, match events set then clear pin 0
    cfg_wr(8'h10, 16'd5);
    cfg_wr(8'h11, 16'd2);
    cfg_wr(8'h12, 16'd4);
    cfg_wr(8'h20, 16'h0010); cfg_wr(8'h30, 16'h01); cfg_wr(8'h40, 16'h1);
    cfg_wr(8'h21, 16'h0020); cfg_wr(8'h31, 16'h01); cfg_wr(8'h51, 16'h1);
    cfg_wr(8'h00, 16'h0001);
    for (int i = 0; i < 12; i++) push(S1_EV[i], S1_PN[i], "R3/R5 wrap and match");
    drain();

    // S2: R4 R7 R8 R10 bounce, state gating, toggle via conflict code 3, stop
    do_reset();
    cfg_wr(8'h10, 16'd3);
    cfg_wr(8'h11, 16'd1);
    cfg_wr(8'h01, 16'h0030);
    cfg_wr(8'h20, 16'h0000); cfg_wr(8'h30, 16'h01); cfg_wr(8'h40, 16'h2); cfg_wr(8'h60, 16'h011);
    cfg_wr(8'h21, 16'h0010); cfg_wr(8'h31, 16'h02); cfg_wr(8'h41, 16'h4);
    cfg_wr(8'h51, 16'h4);    cfg_wr(8'h61, 16'h021);
    cfg_wr(8'h22, 16'h0010); cfg_wr(8'h32, 16'h04); cfg_wr(8'h42, 16'h8); cfg_wr(8'h62, 16'h200);
    cfg_wr(8'h00, 16'h0003);
    for (int i = 0; i < 12; i++) push(S2_EV[i], S2_PN[i], "R4/R7/R8/R10 bounce state stop");
    drain();

    // S3: R6 R9 R10 R11 input start, simultaneous set/clear, level reverse
    do_reset();
    cfg_wr(8'h10, 16'd10);
    cfg_wr(8'h11, 16'd2);
    cfg_wr(8'h01, 16'h0004);
    cfg_wr(8'h20, 16'h0001); cfg_wr(8'h30, 16'h01); cfg_wr(8'h40, 16'h3); cfg_wr(8'h60, 16'h100);
    cfg_wr(8'h21, 16'h0001); cfg_wr(8'h31, 16'h01); cfg_wr(8'h51, 16'h3);
    cfg_wr(8'h22, 16'h0013); cfg_wr(8'h32, 16'h01); cfg_wr(8'h62, 16'h400);
    cfg_wr(8'h23, 16'h0010); cfg_wr(8'h33, 16'h01); cfg_wr(8'h43, 16'h4);
    @(posedge clk); #1;
    pin_in[0] = 1'b1;
    for (int i = 0; i < 15; i++) push(S3_EV[i], S3_PN[i], "R6/R9/R10/R11 inputs conflict reverse");
    repeat (5) @(posedge clk);
    #1 pin_in[1] = 1'b1;
    @(posedge clk);
    #1 pin_in[1] = 1'b0;
    drain();

    // S4: R10 R4 reverse coinciding with the bounce turn at the limit
    do_reset();
    cfg_wr(8'h10, 16'd3);
    cfg_wr(8'h11, 16'd1);
    cfg_wr(8'h20, 16'h0000); cfg_wr(8'h30, 16'h01); cfg_wr(8'h60, 16'h400);
    cfg_wr(8'h21, 16'h0010); cfg_wr(8'h31, 16'h01); cfg_wr(8'h41, 16'h1);
    cfg_wr(8'h00, 16'h0003);
    for (int i = 0; i < 12; i++) push(S4_EV[i], S4_PN[i], "R10 reverse at limit turn");
    drain();

    summary();
    $finish;
  end
endmodule